// File: doc/BRIEF.md
# Tone Steering Guard-Time Validator

This block sits behind the detector of a dual-tone receiver. The detector raises a raw presence flag whenever it believes both tones are there. That flag flickers at the start and end of a burst, and it drops out briefly in the middle of a burst. The validator turns it into a clean steering output. The output rises only when the flag has been held for a qualifying period. Once high, it survives dropouts shorter than a separate release period.

Both periods are measured in system clock cycles by a single shared counter. A four-state machine steers that counter: idle, qualifying on, valid, and qualifying off. The two periods are build parameters and can differ, which gives the block asymmetric hysteresis. A powerdown input forces the output low and sends the machine back to idle. A one-cycle strobe marks each newly validated digit, so the decoded code can be captured downstream.

All inputs are synchronous to `clk`, and every input is sampled at the rising edge.

Top module: `tone_guard_validator`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `steer_o` and `strobe_o` are both low and the machine is idle.
- R2: When `steer_o` is low, it goes high right after the rising edge that samples `tone_raw_i` high for the ON_CYCLES-th consecutive time. No earlier edge raises it.
- R3: A high run of `tone_raw_i` shorter than ON_CYCLES leaves `steer_o` low. The next qualification then starts counting from zero.
- R4: While `steer_o` is high, a low run of `tone_raw_i` shorter than OFF_CYCLES leaves `steer_o` high. A later dropout then starts its count from zero.
- R5: When `steer_o` is high, it goes low right after the edge that samples `tone_raw_i` low for the OFF_CYCLES-th consecutive time.
- R6: While `pwrdn_i` is high, `steer_o` and `strobe_o` are low in that same cycle. Each edge that samples `pwrdn_i` high returns the machine to idle and clears both counts. After release, a full ON_CYCLES run is needed again.
- R7: `strobe_o` is high for exactly one cycle, which is the first cycle in which `steer_o` is high after being low. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pwrdn_i | input | 1 | Powerdown request, active high |
| tone_raw_i | input | 1 | Raw early tone-presence flag |
| steer_o | output | 1 | Validated steering output |
| strobe_o | output | 1 | One-cycle pulse when a digit is newly validated |

## Verification
The bench builds the block with ON_CYCLES = 5 and OFF_CYCLES = 3. Both periods stay short, so every run length around each threshold is reached within a few cycles: one short, exactly at the threshold, and one over. Because the two values differ, a fault that swaps or shares the two limits shows up at once. Random bursts with rare powerdown pulses reach the interleavings that the directed cases do not list, such as a dropout that ends exactly on the last cycle of the release count.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_QUAL_ON  = 2'd1,
        ST_VALID    = 2'd2,
        ST_QUAL_OFF = 2'd3
    } tsg_state_t;

    typedef struct packed {
        logic clr;
        logic load1;
        logic inc;
    } tsg_cnt_ctl_t;

    function automatic int tsg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int tsg_cnt_width(input int on_c, input int off_c);
        return $clog2(tsg_max(on_c, off_c) + 1);
    endfunction

    function automatic logic tsg_is_steering(input tsg_state_t s);
        return (s == ST_VALID) || (s == ST_QUAL_OFF);
    endfunction

endpackage

// File: rtl/tsg_guard_counter.sv
module tsg_guard_counter
    import tsg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  tsg_cnt_ctl_t ctl,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt <= '0;
        end else if (ctl.load1) begin
            cnt <= W'(1);
        end else if (ctl.inc) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/tsg_fsm.sv
module tsg_fsm
    import tsg_pkg::*;
#(
    parameter int ON_CYCLES  = 5,
    parameter int OFF_CYCLES = 3,
    parameter int W          = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwrdn_i,
    input  logic         tone_raw_i,
    input  logic [W-1:0] cnt,
    output tsg_state_t   state,
    output tsg_cnt_ctl_t ctl
);

    localparam logic [W-1:0] ON_LAST  = W'(ON_CYCLES - 1);
    localparam logic [W-1:0] OFF_LAST = W'(OFF_CYCLES - 1);

    tsg_state_t nxt;

    always_comb begin
        nxt = state;
        ctl = '0;
        if (pwrdn_i) begin
            nxt     = ST_IDLE;
            ctl.clr = 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tone_raw_i) begin
                        nxt       = ST_QUAL_ON;
                        ctl.load1 = 1'b1;
                    end else begin
                        ctl.clr = 1'b1;
                    end
                end
                ST_QUAL_ON: begin
                    if (!tone_raw_i) begin
                        nxt     = ST_IDLE;
                        ctl.clr = 1'b1;
                    end else if (cnt == ON_LAST) begin
                        nxt     = ST_VALID;
                        ctl.clr = 1'b1;
                    end else begin
                        ctl.inc = 1'b1;
                    end
                end
                ST_VALID: begin
                    if (!tone_raw_i) begin
                        nxt       = ST_QUAL_OFF;
                        ctl.load1 = 1'b1;
                    end else begin
                        ctl.clr = 1'b1;
                    end
                end
                default: begin
                    if (tone_raw_i) begin
                        nxt     = ST_VALID;
                        ctl.clr = 1'b1;
                    end else if (cnt == OFF_LAST) begin
                        nxt     = ST_IDLE;
                        ctl.clr = 1'b1;
                    end else begin
                        ctl.inc = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/tsg_strobe.sv
module tsg_strobe (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_i,
    input  logic steer_raw,
    output logic steer_o,
    output logic strobe_o
);

    logic steer_prev;

    always_ff @(posedge clk) begin
        if (rst || pwrdn_i) begin
            steer_prev <= 1'b0;
        end else begin
            steer_prev <= steer_raw;
        end
    end

    assign steer_o  = steer_raw & ~pwrdn_i;
    assign strobe_o = steer_raw & ~steer_prev & ~pwrdn_i;

endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator
    import tsg_pkg::*;
#(
    parameter int ON_CYCLES  = 5,
    parameter int OFF_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_i,
    input  logic tone_raw_i,
    output logic steer_o,
    output logic strobe_o
);

    localparam int W = tsg_cnt_width(ON_CYCLES, OFF_CYCLES);

    tsg_state_t   state;
    tsg_cnt_ctl_t ctl;
    logic [W-1:0] cnt;
    logic         steer_raw;

    tsg_fsm #(
        .ON_CYCLES (ON_CYCLES),
        .OFF_CYCLES(OFF_CYCLES),
        .W         (W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pwrdn_i   (pwrdn_i),
        .tone_raw_i(tone_raw_i),
        .cnt       (cnt),
        .state     (state),
        .ctl       (ctl)
    );

    tsg_guard_counter #(
        .W(W)
    ) u_cnt (
        .clk(clk),
        .rst(rst),
        .ctl(ctl),
        .cnt(cnt)
    );

    assign steer_raw = tsg_is_steering(state);

    tsg_strobe u_strobe (
        .clk      (clk),
        .rst      (rst),
        .pwrdn_i  (pwrdn_i),
        .steer_raw(steer_raw),
        .steer_o  (steer_o),
        .strobe_o (strobe_o)
    );

endmodule

// File: rtl/tsg_checker.sv
module tsg_checker
    import tsg_pkg::*;
#(
    parameter int ON_CYCLES  = 5,
    parameter int OFF_CYCLES = 3,
    parameter int W          = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         pwrdn_i,
    input logic         tone_raw_i,
    input logic         steer_o,
    input logic         strobe_o,
    input tsg_state_t   state,
    input logic [W-1:0] cnt
);

    localparam int CMAX = tsg_max(ON_CYCLES, OFF_CYCLES);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!steer_o && !strobe_o && state == ST_IDLE)); // R1

    AST_RISE_NEEDS_TONE: assert property (@(posedge clk) disable iff (rst) $rose(steer_o) |-> $past(tone_raw_i)); // R2

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst) int'(cnt) < CMAX); // R3

    AST_FALL_NEEDS_GAP: assert property (@(posedge clk) disable iff (rst) ($fell(steer_o) && !pwrdn_i) |-> !$past(tone_raw_i)); // R5

    AST_PWRDN_TO_IDLE: assert property (@(posedge clk) disable iff (rst) $past(pwrdn_i) |-> (state == ST_IDLE && cnt == '0)); // R6

    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst) strobe_o |-> (steer_o && !$past(steer_o))); // R7

endmodule

bind tone_guard_validator tsg_checker #(
    .ON_CYCLES (ON_CYCLES),
    .OFF_CYCLES(OFF_CYCLES),
    .W         (W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwrdn_i   (pwrdn_i),
    .tone_raw_i(tone_raw_i),
    .steer_o   (steer_o),
    .strobe_o  (strobe_o),
    .state     (state),
    .cnt       (cnt)
);

// File: tb/tone_guard_validator_test.sv
module tone_guard_validator_test;

    localparam int ON_C  = 5;
    localparam int OFF_C = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwrdn_i = 1'b0;
    logic tone_raw_i = 1'b0;
    logic steer_o, strobe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int  hi_run = 0;
    int  lo_run = 0;
    bit  st_m = 1'b0;
    bit  prev_m = 1'b0;
    int  strobes = 0;

    always #2 clk = ~clk;

    tone_guard_validator #(.ON_CYCLES(ON_C), .OFF_CYCLES(OFF_C)) uut (
        .clk(clk), .rst(rst), .pwrdn_i(pwrdn_i), .tone_raw_i(tone_raw_i),
        .steer_o(steer_o), .strobe_o(strobe_o)
    );

    function automatic bit exp_strobe(input bit now_s, input bit was_s);
        return now_s && !was_s;
    endfunction

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic model_edge(input bit t, input bit p);
        prev_m = st_m;
        if (p) begin
            hi_run = 0; lo_run = 0; st_m = 1'b0;
        end else if (t) begin
            hi_run++; lo_run = 0;
            if (!st_m && hi_run >= ON_C) st_m = 1'b1;
        end else begin
            lo_run++; hi_run = 0;
            if (st_m && lo_run >= OFF_C) st_m = 1'b0;
        end
    endtask

    // drive at negedge, advance one edge, compare at next negedge
    task automatic step(input bit t, input bit p, input string tag);
        tone_raw_i = t;
        pwrdn_i = p;
        @(posedge clk);
        model_edge(t, p);
        @(negedge clk);
        check(tag, "steer_o", steer_o, st_m);
        check(tag, "strobe_o", strobe_o, exp_strobe(st_m, prev_m));
        if (strobe_o) strobes++;
    endtask

    task automatic run(input bit t, input int n, input string tag);
        for (int i = 0; i < n; i++) step(t, 1'b0, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int s0;
        bit t, p;
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "steer_o in reset", steer_o, 1'b0);
        check("R1", "strobe_o in reset", strobe_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "steer_o after reset", steer_o, 1'b0);
        check("R1", "strobe_o after reset", strobe_o, 1'b0);

        // R3: short high runs never qualify and do not accumulate
        run(1'b1, ON_C - 1, "R3");
        run(1'b0, 1, "R3");
        run(1'b1, ON_C - 1, "R3");
        check("R3", "steer_o after short run", steer_o, 1'b0);
        run(1'b0, 2, "R3");

        // R2, R7: exact qualification and single strobe
        s0 = strobes;
        run(1'b1, ON_C - 1, "R2");
        check("R2", "steer_o one sample early", steer_o, 1'b0);
        step(1'b1, 1'b0, "R2");
        check("R2", "steer_o at threshold", steer_o, 1'b1);
        check("R7", "strobe_o at rise", strobe_o, 1'b1);
        run(1'b1, 4, "R7");
        check("R7", "strobe count per rise", (strobes - s0) == 1, 1'b1);

        // R4: dropouts shorter than OFF, repeated, keep steering
        run(1'b0, OFF_C - 1, "R4");
        run(1'b1, 1, "R4");
        run(1'b0, OFF_C - 1, "R4");
        check("R4", "steer_o after short dropouts", steer_o, 1'b1);
        check("R4", "no strobe on recovery", strobe_o, 1'b0);
        run(1'b1, 2, "R4");

        // R5: exact release
        run(1'b0, OFF_C - 1, "R5");
        check("R5", "steer_o one sample early", steer_o, 1'b1);
        step(1'b0, 1'b0, "R5");
        check("R5", "steer_o at release", steer_o, 1'b0);

        // R6: powerdown while valid and mid-qualification
        run(1'b1, ON_C + 1, "R6");
        step(1'b1, 1'b1, "R6");
        check("R6", "steer_o in powerdown", steer_o, 1'b0);
        run(1'b1, ON_C - 1, "R6");
        check("R6", "steer_o needs full run after powerdown", steer_o, 1'b0);
        step(1'b1, 1'b0, "R6");
        check("R6", "steer_o after full run", steer_o, 1'b1);
        check("R7", "strobe_o after powerdown requalify", strobe_o, 1'b1);
        run(1'b1, 2, "R6");
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        check("R6", "strobe_o in powerdown", strobe_o, 1'b0);
        run(1'b1, 2, "R6");
        step(1'b1, 1'b1, "R6");
        run(1'b0, 3, "R6");

        // random bursts with rare powerdown
        t = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 4) == 0) t = ~t;
            p = (($urandom % 64) == 0);
            step(t, p, "R2");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule